// File: doc/BRIEF.md
# Countdown Timer With Interrupt Summary

This block holds a single 32-bit timer word in which a countdown value, a count enable, an interrupt enable and a write-one acknowledge bit are packed together. Software writes the word to load a count and arm the timer. The count then steps down by one on every cycle where the tick input is high, and it stops at zero. If the interrupt enable is set when the count passes from one to zero, a sticky timer interrupt flag is raised. That flag stays up until software writes the timer word again with the acknowledge bit set.

A second, read-only status word collects the timer flag together with five external interrupt request lines: playback, capture, serial audio output, game port and MIDI port. One combined interrupt output is high whenever any status bit is high. Access goes through a simple port: a write strobe, an address, write data, and read data that follows the address combinationally. The tick input comes from an external prescaler.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset the count, the count enable, the interrupt enable and the timer flag are all zero. With all external requests low, `irq_out` is low.
- R2: A write to offset 0x60 loads the count from bits 19:0, the count enable from bit 24 and the interrupt enable from bit 25. Reading offset 0x60 returns those fields in the same positions. Every other bit, bit 26 included, reads zero.
- R3: When the count enable is set and `tick` is high, the count drops by one per clock. When `tick` is low or the count enable is clear, the count holds.
- R4: A count of zero stays at zero under further ticks and never wraps.
- R5: The timer flag is set only on a tick that takes the count from 1 to 0 while the interrupt enable is set. Loading zero does not set it, and neither does reaching zero with the interrupt enable clear.
- R6: Once set, the timer flag stays set until a write to offset 0x60 has bit 26 set. That write clears it. A write to 0x60 with bit 26 clear leaves it as it is.
- R7: Reading offset 0x64 returns the status word. External requests `ext_irq[0..4]` (playback, capture, serial audio out, game port, MIDI) appear in bits 0..4, the timer flag in bit 5, and bits 31:6 read zero.
- R8: `irq_out` is high exactly when at least one status bit is high.
- R9: When a write to 0x60 and a tick fall in the same cycle, the written value is loaded and no decrement happens in that cycle.
- R10: Reads from any offset other than 0x60 and 0x64 return zero. Writes to any other offset change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Register offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| tick | input | 1 | Count step enable from the prescaler |
| ext_irq | input | 5 | External requests: playback, capture, serial out, game port, MIDI |
| irq_out | output | 1 | OR of all status bits |

## Verification
The bench builds the timer with a 4-bit count field and keeps the default bit positions and offsets. The narrow field makes two exhaustive sweeps affordable. The first covers every load value, counted all the way down, once with the interrupt enable set and once with it clear, which exercises every 1-to-0 transition and the stop at zero. The second covers all 32 patterns of the external request lines, each with the timer flag both clear and set. Further directed cases cover acknowledge with and without bit 26, a write and a tick in the same cycle, and unmapped offsets.

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer #(
  parameter int CNT_W = 20,
  parameter int EXT_N = 5,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] TIMER_OFS = 8'h60,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 8'h64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              tick,
  input  logic [EXT_N-1:0]  ext_irq,
  output logic              irq_out
);
  localparam int RUN_BIT = 24;
  localparam int IEN_BIT = 25;
  localparam int ACK_BIT = 26;
  localparam int TFLAG_BIT = EXT_N;

  logic [CNT_W-1:0] count;
  logic cnt_en, irq_en, pending;

  wire wr_hit = wr_en && (addr == TIMER_OFS);
  wire step   = tick && cnt_en && (count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      cnt_en  <= 1'b0;
      irq_en  <= 1'b0;
      pending <= 1'b0;
    end else if (wr_hit) begin
      count  <= wdata[CNT_W-1:0];
      cnt_en <= wdata[RUN_BIT];
      irq_en <= wdata[IEN_BIT];
      if (wdata[ACK_BIT]) pending <= 1'b0;
    end else if (step) begin
      count <= count - CNT_W'(1);
      if (count == CNT_W'(1) && irq_en) pending <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == TIMER_OFS) begin
      rdata[CNT_W-1:0] = count;
      rdata[RUN_BIT]   = cnt_en;
      rdata[IEN_BIT]   = irq_en;
    end else if (addr == STATUS_OFS) begin
      rdata[EXT_N-1:0] = ext_irq;
      rdata[TFLAG_BIT] = pending;
    end
  end

  assign irq_out = pending || (|ext_irq);
endmodule

// File: rtl/irq_countdown_timer_chk.sv
module irq_countdown_timer_chk #(
  parameter int CNT_W = 20,
  parameter int EXT_N = 5,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] TIMER_OFS = 8'h60,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 8'h64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              tick,
  input logic [EXT_N-1:0]  ext_irq,
  input logic              irq_out,
  input logic [CNT_W-1:0]  count,
  input logic              cnt_en,
  input logic              irq_en,
  input logic              pending
);
  wire wr_t = wr_en && (addr == TIMER_OFS);

  // R2 R9
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_t |=> count == $past(wdata[CNT_W-1:0]));
  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_t && tick && cnt_en && count != '0 |=> count == $past(count) - CNT_W'(1));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_t && !(tick && cnt_en) |=> $stable(count));
  // R4
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_t && count == '0 |=> count == '0);
  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(count) == CNT_W'(1) && $past(irq_en) && $past(tick) && $past(cnt_en));
  // R6
  ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_t && wdata[26] |=> !pending);
  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !(wr_t && wdata[26]) |=> pending);
  // R7
  status_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr == STATUS_OFS |-> rdata[31:EXT_N+1] == '0 && rdata[EXT_N] == pending);
  // R8
  irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (pending || ext_irq != '0));
endmodule

bind irq_countdown_timer irq_countdown_timer_chk #(
  .CNT_W(CNT_W), .EXT_N(EXT_N), .ADDR_W(ADDR_W),
  .TIMER_OFS(TIMER_OFS), .STATUS_OFS(STATUS_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .tick(tick), .ext_irq(ext_irq), .irq_out(irq_out),
  .count(count), .cnt_en(cnt_en), .irq_en(irq_en), .pending(pending)
);

// File: tb/irq_countdown_timer_test.sv
module irq_countdown_timer_test;
  localparam int CW = 4;
  localparam logic [7:0] TOFS = 8'h60;
  localparam logic [7:0] SOFS = 8'h64;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, tick = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [31:0] wdata = '0, rdata;
  logic [4:0] ext_irq = '0;
  logic irq_out;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_countdown_timer #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tick(tick), .ext_irq(ext_irq), .irq_out(irq_out));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic with_tick = 1'b0);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1; tick = with_tick;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic tk(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
  endtask

  function automatic logic [31:0] tw(int v, bit run, bit ien, bit ack);
    return 32'(v) | (32'(run) << 24) | (32'(ien) << 25) | (32'(ack) << 26);
  endfunction

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000 && !done) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected<=100000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(TOFS, d); chk("R1 timer word", d, 0);
    rd(SOFS, d); chk("R1 status word", d, 0);
    chk("R1 irq_out", 32'(irq_out), 0);

    // R2 field placement and readback, bit 26 reads zero
    wr(TOFS, tw(9, 1, 0, 1) | 32'h00F0_0000);
    rd(TOFS, d); chk("R2 readback", d, tw(9, 1, 0, 0));
    wr(TOFS, tw(5, 0, 1, 0));
    rd(TOFS, d); chk("R2 readback ien", d, tw(5, 0, 1, 0));

    // R3 hold while disabled, and while tick is low
    tk(3); rd(TOFS, d); chk("R3 hold disabled", d[CW-1:0], 5);
    wr(TOFS, tw(5, 1, 0, 0));
    repeat (4) @(negedge clk);
    rd(TOFS, d); chk("R3 hold no tick", d[CW-1:0], 5);

    // R3 R4 R5 exhaustive load sweep with and without interrupt enable
    for (int ien = 0; ien < 2; ien++) begin
      for (int v = 0; v < (1 << CW); v++) begin
        wr(TOFS, tw(v, 1, ien != 0, 1));
        rd(SOFS, d); chk("R6 ack on load", 32'(d[5]), 0);
        for (int k = 1; k <= v + 2; k++) begin
          tk(1);
          rd(TOFS, d);
          chk((k > v) ? "R4 stop at zero" : "R3 decrement", d[CW-1:0], (k >= v) ? 0 : v - k);
          rd(SOFS, d);
          chk("R5 flag on 1->0", 32'(d[5]), 32'((ien != 0) && (v > 0) && (k >= v)));
        end
      end
    end

    // R6 write without ack keeps flag, with ack clears
    wr(TOFS, tw(1, 1, 1, 0)); tk(1);
    rd(SOFS, d); chk("R5 set", 32'(d[5]), 1);
    wr(TOFS, tw(3, 0, 0, 0));
    rd(SOFS, d); chk("R6 no ack keeps", 32'(d[5]), 1);
    chk("R8 irq from timer", 32'(irq_out), 1);
    wr(TOFS, tw(3, 0, 0, 1));
    rd(SOFS, d); chk("R6 ack clears", 32'(d[5]), 0);
    chk("R8 irq low", 32'(irq_out), 0);

    // R9 write and tick together: load wins
    wr(TOFS, tw(7, 1, 0, 0));
    wr(TOFS, tw(12, 1, 0, 0), 1'b1);
    rd(TOFS, d); chk("R9 write beats tick", d[CW-1:0], 12);

    // R7 R8 sweep all external patterns, flag clear then set
    for (int f = 0; f < 2; f++) begin
      if (f == 1) begin wr(TOFS, tw(1, 1, 1, 0)); tk(1); end
      for (int p = 0; p < 32; p++) begin
        @(negedge clk); ext_irq = 5'(p);
        rd(SOFS, d);
        chk("R7 status word", d, 32'(p) | (32'(f) << 5));
        chk("R8 irq_out", 32'(irq_out), 32'((p != 0) || (f != 0)));
      end
    end
    @(negedge clk); ext_irq = '0;

    // R10 unmapped read and write
    wr(TOFS, tw(6, 0, 1, 1));
    rd(8'h62, d); chk("R10 unmapped read", d, 0);
    rd(8'h00, d); chk("R10 unmapped read 0", d, 0);
    wr(8'h68, tw(2, 1, 0, 1));
    wr(8'h64, tw(3, 1, 0, 0));
    rd(TOFS, d); chk("R10 write elsewhere ignored", d, tw(6, 0, 1, 0));

    finish_run();
  end
endmodule